// File: doc/BRIEF.md
# Sign-Steered Distributed-Arithmetic Dot Product Engine

This block forms the sum of K fixed coefficients multiplied by K signed input words without any multiplier. Each input bit is read as +1 or -1 instead of 1 or 0. With that reading, the partial sums for a bit pattern and for its complement are the same value with opposite sign. A constant table therefore needs only 2^(K-1) entries. One input's bit (input 0) chooses between the direct and the complemented table address, and it also chooses whether the adder adds or subtracts the entry. A constant equal to minus the coefficient sum seeds the accumulator. One adder/subtractor then walks the input bits from the least significant end. After every step it shifts the running sum right, and the bits that fall off the bottom are kept as the low part of the result.

Inputs are integers in two's complement (equivalently N-bit fractions scaled by 2^(N-1)). A pulse on `start` while the engine is idle captures all K inputs. Exactly N clock edges later, `done` pulses for one clock and `result` carries the exact integer inner product. The coefficients are parameters, packed with coefficient k in bits [k*CW +: CW].

Top module: `da_ob_dot`

## Requirements
- R1: While `rst_n` is low and after it is released, `busy` is 0, `done` is 0 and `result` is 0 until the first operation completes.
- R2: For any inputs, `result` equals the exact signed integer sum over k of COEF_k times x_k, where x_k is `in_vec[k*N +: N]` read as two's complement and COEF_k is `COEFS[k*CW +: CW]` read as two's complement.
- R3: A `start` sampled high at a clock edge while `busy` is 0 makes `done` rise exactly N edges later, and `done` stays high for one clock only.
- R4: `busy` is 1 from the edge that accepts `start` until the edge that raises `done`, and `busy` and `done` are never high together.
- R5: A `start` pulse while `busy` is 1 is ignored: it yields no extra `done`, and the running operation's `result` is unchanged.
- R6: `result` changes only at the edge that raises `done` and holds its value otherwise.
- R7: The sign position is weighted by minus its power of two, so inputs at the most negative value, at the most positive value and at zero give exact results, including all inputs at the most negative value together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation; sampled only when idle |
| in_vec | input | K*N | K packed signed input words, word k at [k*N +: N] |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock pulse when `result` has been updated |
| result | output | CW+clog2(K)+N+1 | Signed inner product, held until the next `done` |

## Verification
The embedded properties assume that `rst_n` is asserted from time zero for at least one edge, and that `start` and `in_vec` change only away from the rising edge. The bench meets this by driving every input on the falling edge and holding reset for several cycles at the start. The properties do not require `start` to stay low while busy. The stimulus deliberately pulses `start` during a run, with different input data, to show that the design ignores it. The inputs cover the full signed range, with one coefficient at its most negative value, so the internal sum and the output width meet their worst-case bounds.

// File: rtl/da_ob_pkg.sv
package da_ob_pkg;
   typedef enum logic {OP_ADD = 1'b0, OP_SUB = 1'b1} da_op_e;

   function automatic int acc_width(input int k_in, input int cw);
      return cw + $clog2(k_in) + 2;
   endfunction
endpackage

// File: rtl/da_ob_table.sv
module da_ob_table #(
   parameter int              K     = 4,
   parameter int              CW    = 12,
   parameter int              AW    = 16,
   parameter logic [K*CW-1:0] COEFS = '0
) (
   input  logic [K-2:0]          addr,
   output logic signed [AW-1:0]  word
);
   localparam int DEPTH = 1 << (K - 1);

   function automatic logic signed [AW-1:0] sext(input logic [CW-1:0] c);
      return {{(AW-CW){c[CW-1]}}, c};
   endfunction

   function automatic logic signed [AW-1:0] entry(input int e);
      logic signed [AW-1:0] s;
      s = sext(COEFS[0 +: CW]);
      for (int k = 1; k < K; k++) begin
         if (((e >> (k - 1)) & 1) != 0) s = s + sext(COEFS[k*CW +: CW]);
         else                           s = s - sext(COEFS[k*CW +: CW]);
      end
      return s;
   endfunction

   logic signed [AW-1:0] rom [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_rom
      assign rom[e] = entry(e);
   end

   assign word = rom[addr];
endmodule

// File: rtl/da_ob_ctrl.sv
module da_ob_ctrl #(
   parameter int N = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic load,
   output logic step,
   output logic last,
   output logic done
);
   localparam int CNTW = (N > 1) ? $clog2(N) : 1;
   localparam logic [CNTW-1:0] LAST_IDX = CNTW'(N - 1);

   logic [CNTW-1:0] cnt;

   assign load = start && !busy;
   assign step = busy;
   assign last = busy && (cnt == LAST_IDX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
         done <= 1'b0;
      end else begin
         done <= last;
         if (load) begin
            busy <= 1'b1;
            cnt  <= '0;
         end else if (busy) begin
            cnt <= cnt + 1'b1;
            if (last) busy <= 1'b0;
         end
      end
   end

   p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_busy_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !last) |=> busy);
   p_done_after_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
      last |=> (done && !busy));
   p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cnt <= LAST_IDX));
endmodule

// File: rtl/da_ob_accum.sv
module da_ob_accum
   import da_ob_pkg::*;
#(
   parameter int N  = 16,
   parameter int AW = 16,
   parameter int RW = AW + N - 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic                 step,
   input  logic                 last,
   input  da_op_e               op,
   input  logic signed [AW-1:0] init,
   input  logic signed [AW-1:0] word,
   output logic signed [RW-1:0] result
);
   logic signed [AW-1:0] hi;
   logic [N-1:0]         lo;
   logic signed [AW-1:0] sum;
   logic signed [AW-1:0] hi_nxt;
   logic [N-1:0]         lo_nxt;

   always_comb begin
      sum    = (op == OP_SUB) ? (hi - word) : (hi + word);
      hi_nxt = sum >>> 1;
      lo_nxt = {sum[0], lo[N-1:1]};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi     <= '0;
         lo     <= '0;
         result <= '0;
      end else if (load) begin
         hi <= init;
         lo <= '0;
      end else if (step) begin
         hi <= hi_nxt;
         lo <= lo_nxt;
         if (last) result <= {hi_nxt, lo_nxt[N-1:1]};
      end
   end

   p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(last) |-> $stable(result));
endmodule

// File: rtl/da_ob_dot.sv
module da_ob_dot
   import da_ob_pkg::*;
#(
   parameter int              K     = 4,
   parameter int              N     = 16,
   parameter int              CW    = 12,
   parameter logic [K*CW-1:0] COEFS = {12'sd2047, -12'sd7, 12'sd1365, -12'sd2048},
   localparam int             AW    = acc_width(K, CW),
   localparam int             RW    = AW + N - 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [K*N-1:0]       in_vec,
   output logic                 busy,
   output logic                 done,
   output logic signed [RW-1:0] result
);
   if (K < 2) begin : g_bad_k
      $error("da_ob_dot: K must be at least 2");
   end
   if (N < 2) begin : g_bad_n
      $error("da_ob_dot: N must be at least 2");
   end
   if (CW < 2) begin : g_bad_cw
      $error("da_ob_dot: CW must be at least 2");
   end

   function automatic logic signed [AW-1:0] neg_coef_sum();
      logic signed [AW-1:0] s;
      s = '0;
      for (int k = 0; k < K; k++)
         s = s - {{(AW-CW){COEFS[k*CW + CW - 1]}}, COEFS[k*CW +: CW]};
      return s;
   endfunction

   localparam logic signed [AW-1:0] SEED = neg_coef_sum();

   logic                  load, step, last;
   logic [K-1:0][N-1:0]   shreg;
   logic [K-1:0]          bits;
   logic [K-2:0]          addr;
   logic signed [AW-1:0]  word;
   da_op_e                op;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg <= '0;
      end else if (load) begin
         shreg <= in_vec;
      end else if (step) begin
         for (int k = 0; k < K; k++) shreg[k] <= shreg[k] >> 1;
      end
   end

   for (genvar k = 0; k < K; k++) begin : g_bits
      assign bits[k] = shreg[k][0];
   end

   for (genvar k = 1; k < K; k++) begin : g_addr
      assign addr[k-1] = bits[k] ~^ bits[0];
   end

   assign op = da_op_e'(~bits[0] ^ last);

   da_ob_ctrl #(.N(N)) u_ctrl (
      .clk  (clk),
      .rst_n(rst_n),
      .start(start),
      .busy (busy),
      .load (load),
      .step (step),
      .last (last),
      .done (done)
   );

   da_ob_table #(.K(K), .CW(CW), .AW(AW), .COEFS(COEFS)) u_table (
      .addr(addr),
      .word(word)
   );

   da_ob_accum #(.N(N), .AW(AW), .RW(RW)) u_accum (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .step  (step),
      .last  (last),
      .op    (op),
      .init  (SEED),
      .word  (word),
      .result(result)
   );

   p_busy_done_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));
   p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);
endmodule

// File: tb/sim_da_ob_dot.sv
module sim_da_ob_dot;
   localparam int              K     = 4;
   localparam int              N     = 16;
   localparam int              CW    = 12;
   localparam logic [K*CW-1:0] COEFS = {12'h7FF, 12'hFF9, 12'h555, 12'h800};
   localparam int              RW    = CW + $clog2(K) + 2 + N - 1;

   typedef struct {
      longint value;
      longint when;
      string  tag;
   } exp_t;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 start = 1'b0;
   logic [K*N-1:0]       in_vec = '0;
   logic                 busy, done;
   logic signed [RW-1:0] result;

   int     n_checks = 0;
   int     n_errors = 0;
   longint cyc = 0;
   exp_t   q[$];
   logic signed [RW-1:0] prev_res = '0;
   int unsigned seed = 32'h1234_5678;

   da_ob_dot #(.K(K), .N(N), .CW(CW), .COEFS(COEFS)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .in_vec(in_vec),
      .busy(busy), .done(done), .result(result)
   );

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic longint model(input logic [K*N-1:0] v);
      longint s = 0;
      for (int k = 0; k < K; k++)
         s += longint'($signed(COEFS[k*CW +: CW])) * longint'($signed(v[k*N +: N]));
      return s;
   endfunction

   task automatic run_op(input logic [K*N-1:0] v, input string tag);
      exp_t e;
      @(negedge clk);
      while (busy) @(negedge clk);
      in_vec = v;
      start  = 1'b1;
      e.value = model(v);
      e.tag   = tag;
      @(posedge clk);
      #1;
      e.when = cyc + N;
      q.push_back(e);
      @(negedge clk);
      start = 1'b0;
      check(busy === 1'b1, "R4 busy after start", longint'(busy), 1);
   endtask

   function automatic logic [K*N-1:0] fill(input logic [N-1:0] w);
      logic [K*N-1:0] v;
      for (int k = 0; k < K; k++) v[k*N +: N] = w;
      return v;
   endfunction

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (busy && done) check(1'b0, "R4 busy and done together", 1, 0);
         if (done) begin
            if (q.size() == 0) begin
               check(1'b0, "R5 unexpected done", 1, 0);
            end else begin
               exp_t e;
               e = q.pop_front();
               check(longint'(result) == e.value, {"R2 result ", e.tag},
                     longint'(result), e.value);
               check(cyc == e.when, {"R3 done timing ", e.tag}, cyc, e.when);
            end
         end else if (result !== prev_res) begin
            check(1'b0, "R6 result changed without done", longint'(result), longint'(prev_res));
         end
         if (done && !$isunknown(done)) begin
            @(negedge clk);
            check(done === 1'b0, "R3 done one cycle", longint'(done), 0);
            if (done) begin
               // keep prev_res consistent after a bad double pulse
            end
         end
         prev_res = result;
      end
   end

   // watchdog
   always @(posedge clk) begin
      if (cyc > 100000) begin
         n_errors++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1 reset state
      check(busy === 1'b0, "R1 busy in reset", longint'(busy), 0);
      check(done === 1'b0, "R1 done in reset", longint'(done), 0);
      check(result === '0, "R1 result in reset", longint'(result), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(busy === 1'b0 && done === 1'b0 && result === '0, "R1 idle after reset",
            longint'(result), 0);

      // R7 extreme values and sign-bit weighting
      run_op(fill(16'h8000), "R7 all most negative");
      run_op(fill(16'h7FFF), "R7 all most positive");
      run_op(fill(16'h0000), "R7 all zero");
      run_op({16'h7FFF, 16'h8000, 16'h7FFF, 16'h8000}, "R7 alternating extremes");
      run_op({16'hFFFF, 16'h0001, 16'hFFFF, 16'h0001}, "R2 plus minus one");
      run_op({16'h0000, 16'h0000, 16'h0000, 16'h0001}, "R2 steering input only");
      run_op({16'h0001, 16'h0000, 16'h0000, 16'h0000}, "R2 last input only");

      // R5 start while busy is ignored
      run_op({16'h1234, 16'hABCD, 16'h0F0F, 16'hF00F}, "R5 first op");
      repeat (2) @(negedge clk);
      in_vec = fill(16'h5A5A);
      start  = 1'b1;
      repeat (3) @(negedge clk);
      start  = 1'b0;
      wait (q.size() == 0);
      repeat (4) @(negedge clk);
      check(busy === 1'b0, "R5 no restart from busy start", longint'(busy), 0);

      // R2 pseudo-random operands, back to back
      for (int i = 0; i < 40; i++) begin
         logic [K*N-1:0] v;
         for (int k = 0; k < K; k++) begin
            seed = seed * 32'd1664525 + 32'd1013904223;
            v[k*N +: N] = seed[31:16];
         end
         run_op(v, "R2 random");
      end

      wait (q.size() == 0);
      repeat (6) @(negedge clk);
      check(done === 1'b0 && busy === 1'b0, "R6 idle hold", longint'(result), longint'(prev_res));
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule